// File: doc/BRIEF.md
# Transceiver Receive Framer

This block sits behind the 8-bit receive port of a USB 2.0 transceiver macrocell and turns its output into a framed byte stream. The transceiver marks a packet with a receive-active envelope and qualifies bytes inside it with a per-cycle valid mask. The framer pushes each received byte downstream with a valid strobe. It tags the final byte of every packet with a last flag and with an error flag that sums up the packet's receive-error history. The downstream side has no ready signal and must accept every beat.

A byte can only be known to be the last one once the envelope has closed. For that reason the framer keeps the newest byte in a one-deep holding register. It releases that byte unmarked when a later byte arrives, or marked last once active has been seen low. An envelope that contains no byte produces a one-cycle empty-packet pulse and no data. A valid strobe that breaks the envelope rules produces a one-cycle protocol-violation pulse, and the offending byte is dropped.

Top module: `utmi_rx_framer`

## Requirements
- R1: A synchronous active-high reset clears the held byte, the error history and the in-packet state. A packet that is open when reset is applied yields no output, and all outputs read 0 in the cycle after a reset edge.
- R2: A byte is accepted only in a cycle where both rxValid and rxActive are high and rxActive was already high in the previous cycle. Accepted bytes leave the block in arrival order with their data unchanged.
- R3: When a byte is accepted while an earlier byte is held, the earlier byte appears on outData with outValid=1 and outLast=0 in the cycle after the accepting clock edge.
- R4: The final byte of a packet appears with outValid=1 and outLast=1 in the cycle after the clock edge at which rxActive is first sampled low.
- R5: A cycle with rxActive high and rxValid low carries no byte and produces no unmarked output beat.
- R6: outError is 1 together with the last byte of a packet exactly when rxError was sampled high in any cycle with rxActive high during that packet. Otherwise it is 0, and it is never 1 on a beat without outLast.
- R7: The error history is cleared at the end of each packet, so an error in one packet does not mark the next one.
- R8: A packet whose envelope opens and closes without an accepted byte produces no outValid beat. It produces a single-cycle emptyPkt pulse in the cycle after active is first sampled low.
- R9: A valid strobe with rxActive low, or in the first cycle of an envelope, raises protoViol for one cycle after that edge, and the byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxData | input | 8 | Received byte from the transceiver |
| rxValid | input | 1 | Byte mask within the envelope |
| rxActive | input | 1 | Packet envelope |
| rxError | input | 1 | Receive error indication |
| outData | output | 8 | Output byte |
| outValid | output | 1 | Output byte strobe |
| outLast | output | 1 | Marks the final byte of a packet |
| outError | output | 1 | Packet error status, valid with outLast |
| emptyPkt | output | 1 | Pulse for an envelope with no byte |
| protoViol | output | 1 | Pulse for a valid strobe outside the rules |

## Verification
The bench sends packets of one byte and of several bytes, with and without masked gap cycles, and watches the exact cycle in which the final byte is released. A design that marks last too early or too late either tags a middle byte or drops the held byte. Errors are placed in a masked gap cycle and in the packet before a clean one. A design that samples error only on valid bytes, or never clears its history, misreports one of those packets. Empty envelopes, valid strobes outside or at the very start of the envelope, and a reset in the middle of a packet catch designs that emit a stray byte, keep a stale one, or accept a byte they should drop.

// File: rtl/utmi_rx_pkg.sv
package utmi_rx_pkg;
  typedef struct packed {
    logic loadHold;
    logic emitMid;
    logic emitEnd;
    logic emitErr;
    logic emptyPulse;
    logic violPulse;
  } rxStrobe_t;
endpackage

// File: rtl/utmi_rx_ctrl.sv
module utmi_rx_ctrl
  import utmi_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rxValid,
  input  logic       rxActive,
  input  logic       rxError,
  output rxStrobe_t  strobe
);
  logic inPkt;
  logic holdFull;
  logic errAcc;
  logic accept;
  logic endSeen;

  always_comb begin
    accept  = rxActive & rxValid & inPkt;
    endSeen = inPkt & ~rxActive;
    strobe.loadHold   = accept;
    strobe.emitMid    = accept & holdFull;
    strobe.emitEnd    = endSeen & holdFull;
    strobe.emitErr    = errAcc;
    strobe.emptyPulse = endSeen & ~holdFull;
    strobe.violPulse  = rxValid & ~(rxActive & inPkt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inPkt    <= 1'b0;
      holdFull <= 1'b0;
      errAcc   <= 1'b0;
    end else begin
      inPkt <= rxActive;
      if (endSeen) begin
        holdFull <= 1'b0;
        errAcc   <= 1'b0;
      end else begin
        if (accept) holdFull <= 1'b1;
        if (rxActive & rxError) errAcc <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/utmi_rx_datapath.sv
module utmi_rx_datapath
  import utmi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rxData,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic              outError,
  output logic              emptyPkt,
  output logic              protoViol
);
  logic [DATA_W-1:0] holdData;
  logic              emitAny;

  assign emitAny = strobe.emitMid | strobe.emitEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdData  <= '0;
      outData   <= '0;
      outValid  <= 1'b0;
      outLast   <= 1'b0;
      outError  <= 1'b0;
      emptyPkt  <= 1'b0;
      protoViol <= 1'b0;
    end else begin
      if (strobe.loadHold) holdData <= rxData;
      if (emitAny) outData <= holdData;
      outValid  <= emitAny;
      outLast   <= strobe.emitEnd;
      outError  <= strobe.emitEnd & strobe.emitErr;
      emptyPkt  <= strobe.emptyPulse;
      protoViol <= strobe.violPulse;
    end
  end
endmodule

// File: rtl/utmi_rx_framer.sv
module utmi_rx_framer
  import utmi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              rxActive,
  input  logic              rxError,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic              outError,
  output logic              emptyPkt,
  output logic              protoViol
);
  rxStrobe_t strobe;

  utmi_rx_ctrl i_ctrl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxActive(rxActive),
    .rxError(rxError), .strobe(strobe)
  );

  utmi_rx_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst(rst), .rxData(rxData), .strobe(strobe),
    .outData(outData), .outValid(outValid), .outLast(outLast),
    .outError(outError), .emptyPkt(emptyPkt), .protoViol(protoViol)
  );
endmodule

// File: rtl/utmi_rx_framer_chk.sv
module utmi_rx_framer_chk (
  input logic clk,
  input logic rst,
  input logic rxValid,
  input logic rxActive,
  input logic outValid,
  input logic outLast,
  input logic outError,
  input logic emptyPkt,
  input logic protoViol
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !outValid && !emptyPkt && !protoViol); // R1
  AST_MID_FROM_BYTE: assert property (@(posedge clk) disable iff (rst) (outValid && !outLast) |-> $past(rxValid && rxActive)); // R3
  AST_LAST_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) outLast |-> outValid && !$past(rxActive) && $past(rxActive, 2)); // R4
  AST_GAP_SILENT: assert property (@(posedge clk) disable iff (rst) (rxActive && !rxValid) |=> !(outValid && !outLast)); // R5
  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (rst) outError |-> outLast); // R6
  AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (rst) emptyPkt |-> !outValid && !$past(rxActive)); // R8
  AST_VIOL_FLAG: assert property (@(posedge clk) disable iff (rst) (rxValid && !rxActive) |=> protoViol); // R9
endmodule

bind utmi_rx_framer utmi_rx_framer_chk i_chk (
  .clk(clk), .rst(rst), .rxValid(rxValid), .rxActive(rxActive),
  .outValid(outValid), .outLast(outLast), .outError(outError),
  .emptyPkt(emptyPkt), .protoViol(protoViol)
);

// File: tb/test_utmi_rx_framer.sv
module test_utmi_rx_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0, rxActive = 1'b0, rxError = 1'b0;
  logic [7:0] outData;
  logic       outValid, outLast, outError, emptyPkt, protoViol;

  int checks = 0, errors = 0;
  int expEmpty = 0, gotEmpty = 0, expViol = 0, gotViol = 0;
  logic [9:0] expQ[$];

  always #4 clk = ~clk;

  utmi_rx_framer i_utmi_rx_framer (
    .clk(clk), .rst(rst), .rxData(rxData), .rxValid(rxValid), .rxActive(rxActive),
    .rxError(rxError), .outData(outData), .outValid(outValid), .outLast(outLast),
    .outError(outError), .emptyPkt(emptyPkt), .protoViol(protoViol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit a, input bit v, input logic [7:0] d, input bit e);
    rxActive = a; rxValid = v; rxData = d; rxError = e;
    @(negedge clk);
  endtask

  // mode: 0 clean, 1 error on middle valid byte, 2 error in the opening masked cycle
  task automatic sendPkt(input int n, input int gapEvery, input int mode, input logic [7:0] seed);
    step(1, 0, 8'h00, mode == 2);
    for (int i = 0; i < n; i++) begin
      if (gapEvery > 0 && (i % gapEvery) == 1) step(1, 0, 8'hEE, 0);
      step(1, 1, seed + 8'(i * 37), (mode == 1) && (i == n / 2));
      expQ.push_back({(i == n - 1) && (mode != 0), i == n - 1, seed + 8'(i * 37)});
    end
    if (n == 0) expEmpty++;
    step(0, 0, 8'h00, 0);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (emptyPkt) gotEmpty++;
      if (protoViol) gotViol++;
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(0, "R2 unexpected byte", int'(outData), 0);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          check(outData == e[7:0], "R2 data", int'(outData), int'(e[7:0]));
          check(outLast == e[8], "R3/R4 last flag", int'(outLast), int'(e[8]));
          check(outError == e[9], "R6/R7 error flag", int'(outError), int'(e[9]));
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check({outValid, outLast, outError, emptyPkt, protoViol} == 5'b0, "R1 reset state",
          int'({outValid, outLast, outError, emptyPkt, protoViol}), 0);
    step(0, 0, 0, 0);

    // R4: last byte timing for a single-byte packet
    step(1, 0, 0, 0);
    step(1, 1, 8'hA5, 0);
    expQ.push_back({1'b0, 1'b1, 8'hA5});
    rxActive = 0; rxValid = 0;
    check(outValid == 0, "R4 no early release", int'(outValid), 0);
    @(negedge clk);
    check(outValid && outLast && outData == 8'hA5, "R4 last timing",
          int'({outValid, outLast, outData}), int'({2'b11, 8'hA5}));
    step(0, 0, 0, 0);

    // R3 timing: first byte out one cycle after second accepted
    step(1, 0, 0, 0);
    step(1, 1, 8'h11, 0);
    expQ.push_back({1'b0, 1'b0, 8'h11});
    step(1, 1, 8'h22, 0);
    expQ.push_back({1'b0, 1'b1, 8'h22});
    check(outValid && !outLast && outData == 8'h11, "R3 mid timing",
          int'({outValid, outLast, outData}), int'({2'b10, 8'h11}));
    // R5: masked cycle emits nothing
    step(1, 0, 8'h99, 0);
    check(!outValid, "R5 gap silent", int'(outValid), 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    sendPkt(5, 0, 0, 8'h30);          // R2 multi-byte
    sendPkt(7, 2, 0, 8'h51);          // R5 gaps
    sendPkt(4, 0, 1, 8'h70);          // R6 error mid
    sendPkt(3, 3, 0, 8'h80);          // R7 clean after error
    sendPkt(2, 0, 2, 8'h90);          // R6 error in masked cycle
    sendPkt(1, 0, 0, 8'hC0);          // R7
    step(0, 0, 0, 0);

    // R8: empty envelope
    sendPkt(0, 0, 0, 8'h00);
    check(emptyPkt && !outValid, "R8 empty pulse", int'({emptyPkt, outValid}), 2);
    step(0, 0, 0, 0);
    check(!emptyPkt, "R8 single cycle", int'(emptyPkt), 0);

    // R9: valid outside envelope, and in first envelope cycle
    step(0, 1, 8'hDD, 0); expViol++;
    check(protoViol && !outValid, "R9 outside", int'({protoViol, outValid}), 2);
    step(0, 0, 0, 0);
    step(1, 1, 8'hDE, 0); expViol++;
    check(protoViol, "R9 first cycle", int'(protoViol), 1);
    step(1, 1, 8'h42, 0);
    expQ.push_back({1'b0, 1'b1, 8'h42});
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    // R1: reset mid-packet discards held byte
    step(1, 0, 0, 0);
    step(1, 1, 8'h5A, 0);
    rst = 1'b1;
    step(1, 0, 0, 0);
    rst = 1'b0;
    check({outValid, emptyPkt, protoViol} == 3'b0, "R1 after reset",
          int'({outValid, emptyPkt, protoViol}), 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check(!outValid, "R1 no stale byte", int'(outValid), 0);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all bytes delivered", expQ.size(), 0);
    check(gotEmpty == expEmpty, "R8 empty count", gotEmpty, expEmpty);
    check(gotViol == expViol, "R9 violation count", gotViol, expViol);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule